// File: doc/BRIEF.md
# SMM Entry Flush Sequencer and Cacheability Gate

This block sits on the system side of a processor bus and turns a platform request for system management mode into correctly ordered pin activity. When the SMM memory region overlays memory that ordinary software can see, the processor will not clean its own cache on entry. The block therefore pairs the interrupt request with a cache flush request, and it makes sure the flush is serviced first. A mode strap selects how that is done. If the pins are synchronous to the processor clock, both may fall on the same clock. If they are not, the flush pin leads the interrupt pin by one full clock.

The block also answers each memory cycle with the active-low cache-enable pin. Two cases force a cycle uncacheable. The first is any cycle strobed between the flush acknowledge and the processor's SMM-active indication, since the processor may prefetch lines in that interval. The second, while shadowing is enabled, is any cycle whose address lies inside the configured SMM region. No flush is generated on the way out of SMM. All three pins are registered and reset to the high (inactive) level.

Top module: `smm_flush_ctl`

## Requirements
- R1: While reset is low, and after the first clock edge in reset, FLUSH#, SMI# and KEN# are all high.
- R2: With shadowing disabled, a request sampled in IDLE drives SMI# low at the next edge, and FLUSH# stays high.
- R3: With shadowing enabled and the mode strap at 0 (synchronous), a request drives FLUSH# and SMI# low at the same edge, one edge after the request is sampled.
- R4: With shadowing enabled and the mode strap at 1 (asynchronous), FLUSH# goes low one edge after the request is sampled and SMI# goes low one edge later. A single-cycle request pulse is enough.
- R5: FLUSH# stays low until the flush acknowledge input is sampled high. It returns high at that edge.
- R6: SMI# stays low until SMM-active is sampled high. It returns high at that edge.
- R7: A request sampled while SMM-active is high, or while the block waits for SMM-active to fall, has no effect. The fall of SMM-active drives neither FLUSH# nor SMI# low.
- R8: A cycle strobed after the flush acknowledge edge and before SMM-active is sampled high returns KEN# high, whatever the address.
- R9: With shadowing enabled, a strobed cycle with base <= address < limit returns KEN# high. An address equal to the limit is not forced.
- R10: Any other strobed cycle sets KEN# to the inverse of the cacheable input, one edge after the strobe. KEN# keeps its value on edges without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| smi_req_i | input | 1 | SMM entry request from platform logic (level or pulse) |
| async_mode_i | input | 1 | Strap: 1 = pins asynchronous, FLUSH# leads SMI# by one clock |
| flush_ack_i | input | 1 | Processor ran its flush-acknowledge cycle |
| smm_active_i | input | 1 | Processor reports it is executing in SMM (active high) |
| cyc_valid_i | input | 1 | Memory cycle address strobe |
| cyc_addr_i | input | ADDR_W | Address of the strobed cycle |
| shadow_en_i | input | 1 | SMM region overlays software-visible memory |
| smram_base_i | input | ADDR_W | First address of the SMM region (inclusive) |
| smram_limit_i | input | ADDR_W | End of the SMM region (exclusive) |
| cache_ok_i | input | 1 | Default cacheability for cycles not forced (1 = cacheable) |
| flush_n_o | output | 1 | Active-low cache flush request pin |
| smi_n_o | output | 1 | Active-low SMM interrupt pin |
| ken_n_o | output | 1 | Active-low cache enable response pin |

## Verification
Every pin is one register away from its inputs. The result of the inputs sampled at an edge is therefore visible just after that same edge. The one exception is asynchronous mode, where SMI# falls one edge after FLUSH#. The bench drives inputs, waits for one rising edge, and samples 2 ns later. The ordering checks step edge by edge and look at both pins at every step, so they catch either pin moving early or late. KEN# is checked once after each strobe edge, and once after an edge with no strobe, to confirm that it holds.

// File: rtl/smm_flush_pkg.sv
// Package: shared types for the SMM entry flush sequencer.
// Assumes nothing beyond IEEE 1800-2017 enums.
package smm_flush_pkg;

    // Entry sequencer states: idle, flush lead (async), awaiting SMM, inside SMM.
    typedef enum logic [1:0] {
        SEQ_IDLE  = 2'd0,
        SEQ_LEAD  = 2'd1,
        SEQ_WAIT  = 2'd2,
        SEQ_INSMM = 2'd3
    } seq_state_e;

endpackage

// File: rtl/smm_entry_seq.sv
// Module: smm_entry_seq
// Orders FLUSH# against SMI# when a platform request arrives, holds each pin
// until the processor answers it, and flags the prefetch window between the
// flush acknowledge and SMM-active.
// Assumes: the mode strap and shadow bit are stable around a request, and
// inputs are already synchronous to clk.
module smm_entry_seq
    import smm_flush_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic smi_req_i,
    input  logic async_mode_i,
    input  logic shadow_en_i,
    input  logic flush_ack_i,
    input  logic smm_active_i,
    output logic flush_n_o,
    output logic smi_n_o,
    output logic prefetch_win_o
);

    seq_state_e state_q;
    logic       flush_q;
    logic       smi_q;
    logic       win_q;
    logic       start;

    // A new request is accepted only from IDLE while the processor is outside SMM.
    always_comb begin
        start = (state_q == SEQ_IDLE) && smi_req_i && !smm_active_i;
    end

    // Sequence state and SMI# request flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SEQ_IDLE;
            smi_q   <= 1'b0;
        end else begin
            unique case (state_q)
                SEQ_IDLE: begin
                    if (start) begin
                        if (shadow_en_i && async_mode_i) begin
                            state_q <= SEQ_LEAD;
                        end else begin
                            state_q <= SEQ_WAIT;
                            smi_q   <= 1'b1;
                        end
                    end
                end
                SEQ_LEAD: begin
                    state_q <= SEQ_WAIT;
                    smi_q   <= 1'b1;
                end
                SEQ_WAIT: begin
                    if (smm_active_i) begin
                        state_q <= SEQ_INSMM;
                        smi_q   <= 1'b0;
                    end
                end
                SEQ_INSMM: begin
                    if (!smm_active_i) begin
                        state_q <= SEQ_IDLE;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    // FLUSH# request: set on a shadowed start, released by the acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flush_q <= 1'b0;
        end else if (flush_q && flush_ack_i) begin
            flush_q <= 1'b0;
        end else if (start && shadow_en_i) begin
            flush_q <= 1'b1;
        end
    end

    // Prefetch window: opens at the acknowledge, closes when SMM-active is seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            win_q <= 1'b0;
        end else if (smm_active_i) begin
            win_q <= 1'b0;
        end else if (flush_q && flush_ack_i) begin
            win_q <= 1'b1;
        end
    end

    // Pin polarity: requests are active-high inside, active-low on the pins.
    always_comb begin
        flush_n_o      = !flush_q;
        smi_n_o        = !smi_q;
        prefetch_win_o = win_q;
    end

    AST_FLUSH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush_n_o && !flush_ack_i) |=> !flush_n_o);          // R5
    AST_FLUSH_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush_n_o && flush_ack_i) |=> flush_n_o);            // R5
    AST_SMI_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!smi_n_o && smm_active_i) |=> smi_n_o);               // R6
    AST_NO_SMI_IN_SMM: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEQ_INSMM) |-> smi_n_o);                   // R7
    AST_ASYNC_FLUSH_LEADS: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(smi_n_o) && async_mode_i && shadow_en_i) |-> $past(!flush_n_o)); // R4

endmodule

// File: rtl/smram_window.sv
// Module: smram_window
// Combinational check of a cycle address against the SMM region.
// Hit means shadowing is on and base <= addr < limit.
// Assumes: base <= limit. A region with base equal to limit is empty.
module smram_window #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ADDR_W-1:0] base_i,
    input  logic [ADDR_W-1:0] limit_i,
    input  logic              enable_i,
    output logic              hit_o
);

    // Inclusive lower bound, exclusive upper bound.
    always_comb begin
        hit_o = enable_i && (addr_i >= base_i) && (addr_i < limit_i);
    end

endmodule

// File: rtl/ken_drive.sv
// Module: ken_drive
// Registers the KEN# response on each cycle strobe: high when forced, otherwise
// the inverse of the default cacheability. Holds between strobes.
// Assumes: the force input is valid in the same cycle as the strobe.
module ken_drive (
    input  logic clk,
    input  logic rst_n,
    input  logic cyc_valid_i,
    input  logic force_i,
    input  logic cache_ok_i,
    output logic ken_n_o
);

    logic ken_n_q;

    // Capture the cacheability answer on a strobe; reset to uncacheable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ken_n_q <= 1'b1;
        end else if (cyc_valid_i) begin
            ken_n_q <= force_i || !cache_ok_i;
        end
    end

    // Drive the pin straight from the register.
    always_comb begin
        ken_n_o = ken_n_q;
    end

    AST_KEN_FORCED: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid_i && force_i) |=> ken_n_o);                 // R9
    AST_KEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_valid_i |=> $stable(ken_n_o));                    // R10

endmodule

// File: rtl/smm_flush_ctl.sv
// Module: smm_flush_ctl (top)
// System-side SMM entry controller. It orders FLUSH# and SMI# for entry and
// answers memory cycles with KEN#, forcing them uncacheable in the prefetch
// window and inside a shadowed SMM region.
// Assumes: synchronous active-low reset, all inputs synchronous to clk.
module smm_flush_ctl #(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smi_req_i,
    input  logic              async_mode_i,
    input  logic              flush_ack_i,
    input  logic              smm_active_i,
    input  logic              cyc_valid_i,
    input  logic [ADDR_W-1:0] cyc_addr_i,
    input  logic              shadow_en_i,
    input  logic [ADDR_W-1:0] smram_base_i,
    input  logic [ADDR_W-1:0] smram_limit_i,
    input  logic              cache_ok_i,
    output logic              flush_n_o,
    output logic              smi_n_o,
    output logic              ken_n_o
);

    logic prefetch_win;
    logic region_hit;
    logic force_unc;

    smm_entry_seq u_seq (
        .clk            (clk),
        .rst_n          (rst_n),
        .smi_req_i      (smi_req_i),
        .async_mode_i   (async_mode_i),
        .shadow_en_i    (shadow_en_i),
        .flush_ack_i    (flush_ack_i),
        .smm_active_i   (smm_active_i),
        .flush_n_o      (flush_n_o),
        .smi_n_o        (smi_n_o),
        .prefetch_win_o (prefetch_win)
    );

    smram_window #(.ADDR_W(ADDR_W)) u_win (
        .addr_i   (cyc_addr_i),
        .base_i   (smram_base_i),
        .limit_i  (smram_limit_i),
        .enable_i (shadow_en_i),
        .hit_o    (region_hit)
    );

    // Either reason forces the cycle uncacheable.
    always_comb begin
        force_unc = prefetch_win || region_hit;
    end

    ken_drive u_ken (
        .clk         (clk),
        .rst_n       (rst_n),
        .cyc_valid_i (cyc_valid_i),
        .force_i     (force_unc),
        .cache_ok_i  (cache_ok_i),
        .ken_n_o     (ken_n_o)
    );

    AST_RESET_PINS_HIGH: assert property (@(posedge clk)
        !rst_n |=> (flush_n_o && smi_n_o && ken_n_o));         // R1
    AST_WINDOW_UNCACHED: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_valid_i && prefetch_win) |=> ken_n_o);            // R8

endmodule

// File: tb/smm_flush_ctl_tb.sv
// Bench for smm_flush_ctl: a KEN# vector table walked by one loop, then
// directed sequences for reset, entry ordering, hold/release and SMM exit.
module smm_flush_ctl_tb;

    localparam int AW = 16;
    localparam logic [AW-1:0] BASE  = 16'h1000;
    localparam logic [AW-1:0] LIMIT = 16'h2000;

    // Vector: {shadow_en, addr[15:0], cache_ok, expected ken_n}
    localparam int NV = 8;
    localparam logic [18:0] VEC [NV] = '{
        {1'b1, 16'h0FFF, 1'b1, 1'b0},
        {1'b1, 16'h1000, 1'b1, 1'b1},
        {1'b1, 16'h1FFF, 1'b1, 1'b1},
        {1'b1, 16'h2000, 1'b1, 1'b0},
        {1'b1, 16'h2000, 1'b0, 1'b1},
        {1'b0, 16'h1800, 1'b1, 1'b0},
        {1'b0, 16'h1800, 1'b0, 1'b1},
        {1'b1, 16'h3000, 1'b0, 1'b1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          smi_req = 1'b0;
    logic          async_mode = 1'b0;
    logic          flush_ack = 1'b0;
    logic          smm_active = 1'b0;
    logic          cyc_valid = 1'b0;
    logic [AW-1:0] cyc_addr = '0;
    logic          shadow_en = 1'b0;
    logic          cache_ok = 1'b1;
    logic          flush_n, smi_n, ken_n;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    smm_flush_ctl #(.ADDR_W(AW)) u_dut (
        .clk           (clk),
        .rst_n         (rst_n),
        .smi_req_i     (smi_req),
        .async_mode_i  (async_mode),
        .flush_ack_i   (flush_ack),
        .smm_active_i  (smm_active),
        .cyc_valid_i   (cyc_valid),
        .cyc_addr_i    (cyc_addr),
        .shadow_en_i   (shadow_en),
        .smram_base_i  (BASE),
        .smram_limit_i (LIMIT),
        .cache_ok_i    (cache_ok),
        .flush_n_o     (flush_n),
        .smi_n_o       (smi_n),
        .ken_n_o       (ken_n)
    );

    task automatic tick();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #800000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual=running expected=finished");
        finish_run();
    end

    initial begin
        // R1: reset level of every pin
        tick();
        tick();
        chk("R1", "flush_n in reset", flush_n, 1'b1);
        chk("R1", "smi_n in reset", smi_n, 1'b1);
        chk("R1", "ken_n in reset", ken_n, 1'b1);
        rst_n = 1'b1;
        tick();

        // R9 / R10: KEN# table
        for (int i = 0; i < NV; i++) begin
            shadow_en = VEC[i][18];
            cyc_addr  = VEC[i][17:2];
            cache_ok  = VEC[i][1];
            cyc_valid = 1'b1;
            tick();
            chk((VEC[i][18] && VEC[i][17:2] >= BASE && VEC[i][17:2] < LIMIT) ? "R9" : "R10",
                $sformatf("ken_n vec %0d", i), ken_n, VEC[i][0]);
        end
        // R10: no strobe, KEN# holds although the default input changes
        cyc_valid = 1'b0;
        cache_ok  = 1'b1;
        shadow_en = 1'b0;
        tick();
        chk("R10", "ken_n hold without strobe", ken_n, 1'b1);

        // R2: no shadowing, SMI# only
        smi_req = 1'b1;
        tick();
        smi_req = 1'b0;
        chk("R2", "smi_n after request", smi_n, 1'b0);
        chk("R2", "flush_n stays high", flush_n, 1'b1);
        // R6: SMI# held while SMM-active is low
        tick();
        tick();
        chk("R6", "smi_n held", smi_n, 1'b0);
        smm_active = 1'b1;
        tick();
        chk("R6", "smi_n released", smi_n, 1'b1);
        // R7: request inside SMM ignored; exit makes no flush
        smi_req = 1'b1;
        tick();
        tick();
        chk("R7", "smi_n with request in SMM", smi_n, 1'b1);
        chk("R7", "flush_n with request in SMM", flush_n, 1'b1);
        smi_req = 1'b0;
        shadow_en = 1'b1;
        smm_active = 1'b0;
        tick();
        tick();
        chk("R7", "smi_n after exit", smi_n, 1'b1);
        chk("R7", "flush_n after exit", flush_n, 1'b1);

        // R3: shadowed, synchronous mode
        async_mode = 1'b0;
        smi_req = 1'b1;
        tick();
        smi_req = 1'b0;
        chk("R3", "flush_n sync", flush_n, 1'b0);
        chk("R3", "smi_n sync", smi_n, 1'b0);
        // R5: held without acknowledge, released with it
        tick();
        chk("R5", "flush_n held", flush_n, 1'b0);
        flush_ack = 1'b1;
        tick();
        flush_ack = 1'b0;
        chk("R5", "flush_n released", flush_n, 1'b1);
        // R8: prefetch in the window is uncacheable, outside the region
        cyc_addr  = 16'h0100;
        cache_ok  = 1'b1;
        cyc_valid = 1'b1;
        tick();
        chk("R8", "ken_n in prefetch window", ken_n, 1'b1);
        cyc_valid = 1'b0;
        smm_active = 1'b1;
        tick();
        chk("R6", "smi_n released (shadowed)", smi_n, 1'b1);
        cyc_valid = 1'b1;
        tick();
        cyc_valid = 1'b0;
        chk("R8", "ken_n after window closed", ken_n, 1'b0);
        smm_active = 1'b0;
        tick();

        // R4: shadowed, asynchronous mode, one-cycle request pulse
        async_mode = 1'b1;
        smi_req = 1'b1;
        tick();
        smi_req = 1'b0;
        chk("R4", "flush_n first edge", flush_n, 1'b0);
        chk("R4", "smi_n still high", smi_n, 1'b1);
        tick();
        chk("R4", "smi_n one clock later", smi_n, 1'b0);
        chk("R4", "flush_n still low", flush_n, 1'b0);
        flush_ack = 1'b1;
        tick();
        flush_ack = 1'b0;
        chk("R5", "flush_n released (async)", flush_n, 1'b1);
        smm_active = 1'b1;
        tick();
        chk("R6", "smi_n released (async)", smi_n, 1'b1);
        smm_active = 1'b0;
        tick();
        tick();
        chk("R7", "no flush on async exit", flush_n, 1'b1);

        finish_run();
    end

endmodule